// File: doc/BRIEF.md
# Two-Line SPI Master Data Shifter

This block is the data path of an SPI master that moves two bits on every SCLK cycle. In place of separate out and in lines, the MOSI and MISO pins together form a 2-bit bus. A direction input picks the mode at the start of a transfer:

- In write mode both pins are outputs and carry outgoing data.
- In read mode both pins are inputs and the block gathers the incoming bits into a word.

Software or a sequencer supplies the mode inputs, a width code, a transmit word and a one-cycle `go` strobe. It then waits for the one-cycle `done` pulse.

The two-line mode is only legal when its enable is set and neither three-wire slave operation nor byte reordering is switched on. A start request under any other combination is refused. The refusal raises an error flag, and the block generates no SCLK edges.

SCLK idles low. Each half period lasts `HALF_DIV` system clocks. Output data changes while SCLK is low and is stable across each rising edge. Input data is sampled on the rising edge.

Top module: `dio_spi_shifter`

## Requirements
- R1: After synchronous reset, `sclk`, `mosi_oe`, `miso_oe`, `mosi_o`, `miso_o`, `done` and `err` are 0 and `rx_data` is 0.
- R2: In write mode, for a width of W bits, the k-th SCLK rising edge (k = 0 first) finds `miso_o` equal to `tx_data[W-1-2k]` and `mosi_o` equal to `tx_data[W-2-2k]`. This means odd-numbered bits go on MISO and even-numbered bits on MOSI, highest pair first. `tx_data` bits at W and above are not sent.
- R3: `width_sel` encodes the width as 0 = 8, 1 = 16, 2 = 24, 3 = 32 bits. A transfer of W bits produces exactly W/2 SCLK rising edges before `done`.
- R4: During a write transfer, `mosi_oe` and `miso_oe` are both 1 at every SCLK rising edge.
- R5: During a read transfer both output enables stay 0. At the k-th rising edge, `miso_in` is taken as bit W-1-2k and `mosi_in` as bit W-2-2k. When `done` pulses, `rx_data` holds the W received bits in its low bits, with all higher bits 0.
- R6: Whenever no transfer is running, both output enables are 0 and `sclk` is 0. `sclk` stays high for a whole half period, and the output data does not change while it is high.
- R7: A `go` while idle is refused when `dual_en` is 0, `three_wire_en` is 1, or `reorder_en` is 1. In that case `err` becomes 1 and no SCLK edge, output enable or `done` follows.
- R8: An accepted `go` clears `err`. `done` is a single-cycle pulse after the last SCLK falling edge.
- R9: A `go` that arrives while a transfer is running is ignored. The running transfer completes with its original data, and no extra SCLK edges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_en | input | 1 | Enables the two-line transfer mode |
| dir_wr | input | 1 | 1 = write to device, 0 = read from device; captured at start |
| width_sel | input | 2 | Transfer width code (0:8, 1:16, 2:24, 3:32 bits) |
| three_wire_en | input | 1 | Three-wire slave mode is active (makes start illegal) |
| reorder_en | input | 1 | Byte reordering is active (makes start illegal) |
| go | input | 1 | Start strobe |
| tx_data | input | 32 | Word to send, right-aligned |
| mosi_in | input | 1 | Sampled MOSI pin level |
| miso_in | input | 1 | Sampled MISO pin level |
| mosi_o | output | 1 | MOSI output value (even bits) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_o | output | 1 | MISO output value (odd bits) |
| miso_oe | output | 1 | MISO output enable |
| sclk | output | 1 | Serial clock, idle low |
| rx_data | output | 32 | Received word, right-aligned |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Last start request was refused |

## Verification
The assertions watch several properties on every cycle:

- The pins are never driven while idle or in read mode.
- SCLK is held low when no transfer runs.
- Output data stays still while SCLK is high.
- A refused start never enters the busy state.
- `done` lasts one cycle, and an accepted start clears the error flag.

Other properties can only be shown by the bench, which acts as the external device. These are the bit-to-pin ordering for each width, the number of SCLK edges, the alignment and zero-fill of the received word, and the fact that a second start request during a transfer leaves the data unchanged.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 5;   // holds up to WORD_W/2 pairs

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } dio_state_e;

    typedef enum logic [1:0] {
        WSEL_8  = 2'd0,
        WSEL_16 = 2'd1,
        WSEL_24 = 2'd2,
        WSEL_32 = 2'd3
    } dio_wsel_e;

    // Pin pair: index 1 is MISO (odd bit), index 0 is MOSI (even bit)
    typedef struct packed {
        logic odd_miso;
        logic even_mosi;
    } dio_pair_t;

    function automatic logic [5:0] width_bits(input logic [1:0] sel);
        logic [5:0] w;
        case (dio_wsel_e'(sel))
            WSEL_8:  w = 6'd8;
            WSEL_16: w = 6'd16;
            WSEL_24: w = 6'd24;
            default: w = 6'd32;
        endcase
        return w;
    endfunction

    function automatic logic mode_legal(input logic dual, input logic tw, input logic ro);
        return dual & ~tw & ~ro;
    endfunction

endpackage

// File: rtl/dio_clkgen.sv
module dio_clkgen #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_cnt;
    logic          tick;

    assign tick     = run && (div_cnt == LAST);
    assign rise_evt = tick && !sclk;
    assign fall_evt = tick && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            sclk    <= ~sclk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R6: serial clock returns to and stays at its idle level when not running
    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk);

    // R6: a high phase never ends early (checked for one cycle of hold)
    assert_sclk_high_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (HALF_DIV > 1 && run && $rose(sclk)) |=> (sclk || !run));

endmodule

// File: rtl/dio_ctrl.sv
module dio_ctrl
    import dio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       dual_en,
    input  logic       dir_wr,
    input  logic [1:0] width_sel,
    input  logic       three_wire_en,
    input  logic       reorder_en,
    input  logic       fall_evt,
    output logic       busy,
    output logic       load,
    output logic       wr_mode,
    output logic       finish,
    output logic       done,
    output logic       err
);
    dio_state_e         state;
    logic [CNT_W-1:0]   pairs_left;
    logic               legal;
    logic               refuse;

    assign legal  = mode_legal(dual_en, three_wire_en, reorder_en);
    assign busy   = (state == ST_SHIFT);
    assign load   = go && !busy && legal;
    assign refuse = go && !busy && !legal;
    assign finish = busy && fall_evt && (pairs_left == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pairs_left <= '0;
            wr_mode    <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        state      <= ST_SHIFT;
                        wr_mode    <= dir_wr;
                        pairs_left <= CNT_W'(width_bits(width_sel) >> 1);
                        err        <= 1'b0;
                    end else if (refuse) begin
                        err <= 1'b1;
                    end
                end
                default: begin
                    if (fall_evt) begin
                        if (pairs_left == CNT_W'(1)) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                        pairs_left <= pairs_left - 1'b1;
                    end
                end
            endcase
        end
    end

    assert_refuse_stays_idle_R7: assert property (@(posedge clk) disable iff (rst)
        refuse |=> (!busy && err));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_accept_clears_err_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> (!err && busy));

    assert_busy_go_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && go && !fall_evt) |=> $stable(pairs_left));

endmodule

// File: rtl/dio_shreg.sv
module dio_shreg
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [1:0]        width_sel,
    input  logic              busy,
    input  logic              wr_mode,
    input  logic              sclk,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              finish,
    input  dio_pair_t         pin_in,
    output dio_pair_t         pin_out,
    output dio_pair_t         pin_oe,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic              drive;

    assign drive = busy && wr_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
        end else begin
            if (load) begin
                tx_sh <= tx_data << (6'd32 - width_bits(width_sel));
                rx_sh <= '0;
            end else if (busy) begin
                if (rise_evt && !wr_mode)
                    rx_sh <= {rx_sh[WORD_W-3:0], pin_in.odd_miso, pin_in.even_mosi};
                if (fall_evt)
                    tx_sh <= tx_sh << 2;
            end
            if (finish && !wr_mode)
                rx_word <= rx_sh;
        end
    end

    assign pin_out.odd_miso  = drive & tx_sh[WORD_W-1];
    assign pin_out.even_mosi = drive & tx_sh[WORD_W-2];
    assign pin_oe            = drive ? 2'b11 : 2'b00;

    assert_idle_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pin_oe == 2'b00));

    assert_read_pins_input_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_mode) |-> (pin_oe == 2'b00));

    assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && sclk && $past(sclk)) |-> $stable(pin_out));

endmodule

// File: rtl/dio_spi_shifter.sv
module dio_spi_shifter
    import dio_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dual_en,
    input  logic        dir_wr,
    input  logic [1:0]  width_sel,
    input  logic        three_wire_en,
    input  logic        reorder_en,
    input  logic        go,
    input  logic [31:0] tx_data,
    input  logic        mosi_in,
    input  logic        miso_in,
    output logic        mosi_o,
    output logic        mosi_oe,
    output logic        miso_o,
    output logic        miso_oe,
    output logic        sclk,
    output logic [31:0] rx_data,
    output logic        done,
    output logic        err
);
    logic      busy, load, wr_mode, finish;
    logic      rise_evt, fall_evt;
    dio_pair_t pin_in, pin_out, pin_oe;

    assign pin_in.odd_miso  = miso_in;
    assign pin_in.even_mosi = mosi_in;

    dio_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .dual_en       (dual_en),
        .dir_wr        (dir_wr),
        .width_sel     (width_sel),
        .three_wire_en (three_wire_en),
        .reorder_en    (reorder_en),
        .fall_evt      (fall_evt),
        .busy          (busy),
        .load          (load),
        .wr_mode       (wr_mode),
        .finish        (finish),
        .done          (done),
        .err           (err)
    );

    dio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    dio_shreg u_shreg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .tx_data   (tx_data),
        .width_sel (width_sel),
        .busy      (busy),
        .wr_mode   (wr_mode),
        .sclk      (sclk),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .finish    (finish),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .rx_word   (rx_data)
    );

    assign mosi_o  = pin_out.even_mosi;
    assign miso_o  = pin_out.odd_miso;
    assign mosi_oe = pin_oe.even_mosi;
    assign miso_oe = pin_oe.odd_miso;

endmodule

// File: tb/dio_spi_shifter_tb.sv
module dio_spi_shifter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_en = 1'b0, dir_wr = 1'b0, three_wire_en = 1'b0, reorder_en = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic        go = 1'b0;
    logic [31:0] tx_data = '0;
    logic        mosi_in = 1'b0, miso_in = 1'b0;
    logic        mosi_o, mosi_oe, miso_o, miso_oe, sclk, done, err;
    logic [31:0] rx_data;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // device model state
    logic        prev_sclk = 1'b0;
    int          total_rise = 0;
    int          oe_hi_rise = 0;
    int          oe_any_rise = 0;
    logic [31:0] cap = '0;
    logic [31:0] rd_src = '0;
    int          rd_w = 0;
    int          rd_base = 0;

    always #2 clk = ~clk;

    dio_spi_shifter u_dut (
        .clk(clk), .rst(rst), .dual_en(dual_en), .dir_wr(dir_wr), .width_sel(width_sel),
        .three_wire_en(three_wire_en), .reorder_en(reorder_en), .go(go), .tx_data(tx_data),
        .mosi_in(mosi_in), .miso_in(miso_in), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_o(miso_o), .miso_oe(miso_oe), .sclk(sclk), .rx_data(rx_data),
        .done(done), .err(err)
    );

    // External device: records pins at SCLK rise, presents read data pairs
    always @(negedge clk) begin
        int k;
        if (sclk && !prev_sclk) begin
            cap = {cap[29:0], miso_o, mosi_o};
            total_rise++;
            if (mosi_oe && miso_oe) oe_hi_rise++;
            if (mosi_oe || miso_oe) oe_any_rise++;
        end
        prev_sclk = sclk;
        k = total_rise - rd_base;
        if (rd_w > 0 && k < rd_w/2) begin
            miso_in = rd_src[rd_w-1-2*k];
            mosi_in = rd_src[rd_w-2-2*k];
        end else begin
            miso_in = 1'b0;
            mosi_in = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input logic [1:0] sel);
        int w = (int'(sel) + 1) * 8;
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    endfunction

    task automatic pulse_go();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
    endtask

    // waits for done; returns 1 if seen, checks single-cycle pulse (R8)
    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        chk("R8 done seen", 32'(seen), 32'd1);
        @(negedge clk);
        chk("R8 done single cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sclk", 32'(sclk), 0);
        chk("R1 oe", {30'd0, miso_oe, mosi_oe}, 0);
        chk("R1 data pins", {30'd0, miso_o, mosi_o}, 0);
        chk("R1 done/err", {30'd0, done, err}, 0);
        chk("R1 rx_data", rx_data, 0);
    endtask

    task automatic t_write(input logic [1:0] sel, input logic [31:0] data);
        int r0, o0;
        bit seen;
        logic [31:0] m = wmask(sel);
        @(negedge clk);
        dual_en = 1'b1; dir_wr = 1'b1; width_sel = sel; tx_data = data; rd_w = 0;
        r0 = total_rise; o0 = oe_hi_rise;
        pulse_go();
        wait_done(seen);
        chk("R3 write rise count", 32'(total_rise - r0), 32'((int'(sel) + 1) * 4));
        chk("R2 write bit mapping", cap & m, data & m);
        chk("R4 oe high at every rise", 32'(oe_hi_rise - o0), 32'((int'(sel) + 1) * 4));
        chk("R6 idle oe/sclk", {29'd0, sclk, miso_oe, mosi_oe}, 0);
    endtask

    task automatic t_read(input logic [1:0] sel, input logic [31:0] src);
        int r0, a0;
        bit seen;
        @(negedge clk);
        dual_en = 1'b1; dir_wr = 1'b0; width_sel = sel; tx_data = 32'hFFFF_FFFF;
        rd_base = total_rise; rd_src = src; rd_w = (int'(sel) + 1) * 8;
        r0 = total_rise; a0 = oe_any_rise;
        @(negedge clk);
        pulse_go();
        wait_done(seen);
        chk("R3 read rise count", 32'(total_rise - r0), 32'((int'(sel) + 1) * 4));
        chk("R5 rx_data alignment", rx_data, src & wmask(sel));
        chk("R5 pins inputs during read", 32'(oe_any_rise - a0), 0);
        rd_w = 0;
    endtask

    task automatic t_illegal(input logic de, input logic tw, input logic ro);
        int r0 = total_rise;
        int dn = 0;
        @(negedge clk);
        dual_en = de; three_wire_en = tw; reorder_en = ro; dir_wr = 1'b1; width_sel = 2'd3;
        tx_data = 32'hDEAD_BEEF;
        pulse_go();
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) dn++;
            if (mosi_oe || miso_oe) dn++;
        end
        chk("R7 err set on refused go", 32'(err), 1);
        chk("R7 no sclk edges", 32'(total_rise - r0), 0);
        chk("R7 no done/oe", 32'(dn), 0);
        three_wire_en = 1'b0; reorder_en = 1'b0;
    endtask

    task automatic t_err_clear();
        @(negedge clk);
        dual_en = 1'b1; dir_wr = 1'b1; width_sel = 2'd0; tx_data = 32'h3C;
        pulse_go();
        chk("R8 err cleared by accepted go", 32'(err), 0);
        begin bit seen; wait_done(seen); end
    endtask

    task automatic t_busy_go();
        int r0;
        bit seen;
        @(negedge clk);
        dual_en = 1'b1; dir_wr = 1'b1; width_sel = 2'd1; tx_data = 32'h0000_9E61;
        r0 = total_rise;
        pulse_go();
        repeat (7) @(negedge clk);
        tx_data = 32'h0000_1234; width_sel = 2'd3;
        pulse_go();
        wait_done(seen);
        chk("R9 rise count unchanged", 32'(total_rise - r0), 32'd8);
        chk("R9 original data sent", cap & 32'hFFFF, 32'h9E61);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write(2'd0, 32'h0000_00A5);
        t_write(2'd1, 32'hFFFF_C3E1);
        t_write(2'd2, 32'h0081_7E42);
        t_write(2'd3, 32'h9A5F_0C36);
        t_read(2'd0, 32'hFFFF_FF96);
        t_read(2'd1, 32'h1234_5A0F);
        t_read(2'd2, 32'hAB6C_39E1);
        t_read(2'd3, 32'hC001_D00D);
        t_illegal(1'b0, 1'b0, 1'b0);
        t_illegal(1'b1, 1'b1, 1'b0);
        t_illegal(1'b1, 1'b0, 1'b1);
        t_err_clear();
        t_busy_go();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule